// File: doc/BRIEF.md
# Autonomous Port Device-Sleep Controller

This block governs the device-sleep sideband of one serial storage port. It watches the port's command traffic. Once the port has had no outstanding work for a programmable number of millisecond ticks, it raises the sleep output on its own, with no software involved. After that it guards the sideband with two timers. The first keeps sleep asserted for a minimum time. The second holds a busy flag after release, so that the link is not used before the device has had time to wake.

Software reaches the block through one 32-bit control word with a write strobe and a read bus that is always valid. The word holds the enable, the exit timeout, the minimum assertion time and the idle base. It also shows two read-only values that the port's capabilities supply: a device-present flag and an idle multiplier.

Separate inputs control when sleep may start. One restricts entry to moments when the interface is already in slumber. A three-bit field blocks each low-power state on its own.

Top module: `idle_sleep_ctrl`

## Requirements
- R1: Control word layout, read at any time on `reg_rdata`:
  - bit 0 is the enable, stored from `reg_wdata[0]` on every write; it reads as the stored value AND `dev_present`.
  - bit 1 reads `dev_present`.
  - bits 9:2 hold the exit timeout, bits 14:10 the minimum assertion time and bits 24:15 the idle base.
  - bits 28:25 read `idle_mult`, and bits 31:29 read zero.
  - After reset, the enable and all three timing fields are zero.
- R2: A write updates the three timing fields only while `engine_run` is low. While it is high the timing fields keep their old values, but the enable bit is still written.
- R3: The idle limit is base × (`idle_mult` + 1) ticks of `ms_tick`. The idle count advances by one on each tick while nothing is outstanding. `devslp` rises on the second clock edge after the tick that makes the count reach the limit.
- R4: `devslp` is never raised in the following cases:
  - `cmd_pending` or `cmd_issue` is high in the cycle before the rise.
  - the effective enable is zero.
  - the idle base is zero.
- R5: The idle count returns to zero on any cycle with `cmd_issue` or `cmd_pending` high, and it restarts from zero after that.
- R6: A wake request (`cmd_issue` or `cmd_pending`) during sleep is held until the minimum assertion time has elapsed. That time is counted in ticks from entry into sleep, and a field value of 0 means 10 ticks. `devslp` falls on the second edge after the tick that completes the minimum.
- R7: After a wake release, `exit_busy` stays high for the exit timeout, counted in ticks, where a field value of 0 means 20 ticks. It then drops and the idle count restarts from zero.
- R8: Clearing the enable during sleep releases `devslp` once the minimum assertion time is met, without raising `exit_busy`. No new entry follows while the enable stays clear.
- R9: While `slumber_only` is high, entry happens only in a cycle where `ifc_state` is 2 (slumber). The other encodings are 0 = active and 1 = partial.
- R10: The `lpm_block` field works bit by bit:
  - bit 2 prevents sleep entry.
  - `lp_allow[0]` is the inverse of bit 0 (partial permitted) and `lp_allow[1]` is the inverse of bit 1 (slumber permitted).
  - `link_hold` is high only when all three bits are set.
- R11: After reset, `devslp` and `exit_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_pending | input | 1 | Commands outstanding to the device |
| cmd_issue | input | 1 | New command request |
| engine_run | input | 1 | Port command engine is running |
| ifc_state | input | 2 | Interface power state: 0 active, 1 partial, 2 slumber |
| slumber_only | input | 1 | Capability: sleep entry only from slumber |
| dev_present | input | 1 | Device-sleep present flag |
| idle_mult | input | 4 | Idle-limit multiplier minus one |
| lpm_block | input | 3 | Per-state transition block bits |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| devslp | output | 1 | Device-sleep sideband |
| exit_busy | output | 1 | Exit timeout in progress |
| lp_allow | output | 2 | Partial (bit 0) and slumber (bit 1) permitted |
| link_hold | output | 1 | All low-power transitions blocked |

## Verification
Each timer decision lands two clock edges after the tick that completes a count: the first edge updates the counter and the second updates the state register that drives `devslp` or `exit_busy`. The bench therefore waits three falling edges after every tick pulse before it samples, and it counts ticks to one short of each limit and then to the limit itself. The control word read-back is combinational on the register state, so it is sampled on the falling edge after the writing rising edge. The gating inputs act through a single registered decision, so a change is sampled two falling edges after it is applied.

// File: rtl/isc_pkg.sv
package isc_pkg;
    // control word field placement (software-visible contract)
    localparam int EN_BIT   = 0;
    localparam int PRES_BIT = 1;
    localparam int DETO_LSB = 2;
    localparam int DETO_W   = 8;
    localparam int MDAT_LSB = 10;
    localparam int MDAT_W   = 5;
    localparam int BASE_LSB = 15;
    localparam int BASE_W   = 10;
    localparam int MULT_LSB = 25;
    localparam int MULT_W   = 4;
    localparam int WORD_W   = 32;
    localparam int LIM_W    = BASE_W + MULT_W + 1;
    localparam int GUARD_W  = (DETO_W > MDAT_W) ? DETO_W : MDAT_W;
    localparam logic [1:0] IFC_SLUMBER = 2'd2;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SLEEP = 2'd1,
        SQ_WAKE  = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic              en;
        logic [DETO_W-1:0] deto;
        logic [MDAT_W-1:0] mdat;
        logic [BASE_W-1:0] base;
    } cfg_t;
endpackage

// File: rtl/isc_cfg_reg.sv
module isc_cfg_reg
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              engine_run,
    input  logic              dev_present,
    input  logic [MULT_W-1:0] mult,
    output cfg_t              cfg,
    output logic [WORD_W-1:0] rdata
);
    cfg_t cfg_d, cfg_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[WORD_W-1:MULT_LSB], wdata[PRES_BIT]};

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en = wdata[EN_BIT];
            if (!engine_run) begin
                cfg_d.deto = wdata[DETO_LSB +: DETO_W];
                cfg_d.mdat = wdata[MDAT_LSB +: MDAT_W];
                cfg_d.base = wdata[BASE_LSB +: BASE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                      = '0;
        rdata[EN_BIT]              = cfg_q.en & dev_present;
        rdata[PRES_BIT]            = dev_present;
        rdata[DETO_LSB +: DETO_W]  = cfg_q.deto;
        rdata[MDAT_LSB +: MDAT_W]  = cfg_q.mdat;
        rdata[BASE_LSB +: BASE_W]  = cfg_q.base;
        rdata[MULT_LSB +: MULT_W]  = mult;
    end

    assign cfg = cfg_q;

    AST_TIMING_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && engine_run) |=> ($stable(cfg_q.deto) && $stable(cfg_q.mdat) && $stable(cfg_q.base))); // R2
endmodule

// File: rtl/isc_idle_timer.sv
module isc_idle_timer
    import isc_pkg::*;
#(
    parameter int CNT_W = LIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || !run)
            cnt_d = '0;
        else if (tick && (cnt_q < limit))
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (limit != '0) && (cnt_q >= limit);

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired || ($past(limit) != limit)); // R5
    AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !expired); // R4
endmodule

// File: rtl/isc_seq.sv
module isc_seq
    import isc_pkg::*;
#(
    parameter int G_W = GUARD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wake_req,
    input  logic           en_hold,
    input  logic           entry_ok,
    input  logic           expired,
    input  logic [G_W-1:0] mdat_lim,
    input  logic [G_W-1:0] deto_lim,
    output logic           devslp,
    output logic           exit_busy,
    output logic           idle_run
);
    typedef struct packed {
        sq_state_e      state;
        logic [G_W-1:0] guard;
        logic           wake;
    } seq_t;

    seq_t s_d, s_q;
    logic guard_tick;
    logic wake_any;

    assign guard_tick = tick && (s_q.guard != {G_W{1'b1}});
    assign wake_any   = s_q.wake || wake_req;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            SQ_IDLE: begin
                s_d.guard = '0;
                s_d.wake  = 1'b0;
                if (entry_ok && expired && !wake_req)
                    s_d.state = SQ_SLEEP;
            end
            SQ_SLEEP: begin
                if (guard_tick) s_d.guard = s_q.guard + G_W'(1);
                if (wake_req)   s_d.wake  = 1'b1;
                if ((wake_any || !en_hold) && (s_q.guard >= mdat_lim)) begin
                    s_d.state = wake_any ? SQ_WAKE : SQ_IDLE;
                    s_d.guard = '0;
                    s_d.wake  = 1'b0;
                end
            end
            SQ_WAKE: begin
                if (guard_tick) s_d.guard = s_q.guard + G_W'(1);
                if (s_q.guard >= deto_lim) begin
                    s_d.state = SQ_IDLE;
                    s_d.guard = '0;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign devslp    = (s_q.state == SQ_SLEEP);
    assign exit_busy = (s_q.state == SQ_WAKE);
    assign idle_run  = (s_q.state == SQ_IDLE);

    AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> $past(!wake_req && en_hold)); // R4
    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devslp) |-> $past(s_q.guard >= mdat_lim)); // R6
    AST_BUSY_FOLLOWS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exit_busy) |-> $past(devslp)); // R7
    AST_DISABLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devslp) && $past(!wake_any)) |-> !exit_busy); // R8
endmodule

// File: rtl/idle_sleep_ctrl.sv
module idle_sleep_ctrl
    import isc_pkg::*;
#(
    parameter int MDAT_DFLT = 10,
    parameter int DETO_DFLT = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    input  logic        cmd_pending,
    input  logic        cmd_issue,
    input  logic        engine_run,
    input  logic [1:0]  ifc_state,
    input  logic        slumber_only,
    input  logic        dev_present,
    input  logic [3:0]  idle_mult,
    input  logic [2:0]  lpm_block,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        devslp,
    output logic        exit_busy,
    output logic [1:0]  lp_allow,
    output logic        link_hold
);
    cfg_t                cfg;
    logic [LIM_W-1:0]    idle_lim;
    logic [GUARD_W-1:0]  mdat_lim;
    logic [GUARD_W-1:0]  deto_lim;
    logic                expired;
    logic                idle_run;
    logic                wake_req;
    logic                en_hold;
    logic                entry_ok;

    isc_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .engine_run  (engine_run),
        .dev_present (dev_present),
        .mult        (idle_mult),
        .cfg         (cfg),
        .rdata       (reg_rdata)
    );

    always_comb begin
        idle_lim = LIM_W'(cfg.base) * (LIM_W'(idle_mult) + LIM_W'(1));
        mdat_lim = (cfg.mdat == '0) ? GUARD_W'(MDAT_DFLT) : GUARD_W'(cfg.mdat);
        deto_lim = (cfg.deto == '0) ? GUARD_W'(DETO_DFLT) : GUARD_W'(cfg.deto);
    end

    assign wake_req = cmd_pending | cmd_issue;
    assign en_hold  = cfg.en & dev_present;
    assign entry_ok = en_hold & ~lpm_block[2]
                    & (~slumber_only | (ifc_state == IFC_SLUMBER));

    isc_idle_timer #(.CNT_W(LIM_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ms_tick),
        .clear   (wake_req),
        .run     (idle_run),
        .limit   (idle_lim),
        .expired (expired)
    );

    isc_seq #(.G_W(GUARD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .wake_req  (wake_req),
        .en_hold   (en_hold),
        .entry_ok  (entry_ok),
        .expired   (expired),
        .mdat_lim  (mdat_lim),
        .deto_lim  (deto_lim),
        .devslp    (devslp),
        .exit_busy (exit_busy),
        .idle_run  (idle_run)
    );

    assign lp_allow  = ~lpm_block[1:0];
    assign link_hold = &lpm_block;

    AST_SLUMBER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> $past(!slumber_only || (ifc_state == IFC_SLUMBER))); // R9
    AST_BLOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> $past(!lpm_block[2])); // R10
    AST_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> $past(cfg.base != '0)); // R4
endmodule

// File: tb/idle_sleep_ctrl_tb.sv
module idle_sleep_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        cmd_pending = 1'b0;
    logic        cmd_issue = 1'b0;
    logic        engine_run = 1'b0;
    logic [1:0]  ifc_state = 2'd0;
    logic        slumber_only = 1'b0;
    logic        dev_present = 1'b1;
    logic [3:0]  idle_mult = 4'd0;
    logic [2:0]  lpm_block = 3'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        devslp;
    logic        exit_busy;
    logic [1:0]  lp_allow;
    logic        link_hold;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_sleep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cmd_pending(cmd_pending),
        .cmd_issue(cmd_issue), .engine_run(engine_run), .ifc_state(ifc_state),
        .slumber_only(slumber_only), .dev_present(dev_present), .idle_mult(idle_mult),
        .lpm_block(lpm_block), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .devslp(devslp), .exit_busy(exit_busy),
        .lp_allow(lp_allow), .link_hold(link_hold)
    );

    // {base[9:0], mult[3:0]}; expected limit = base*(mult+1)
    localparam logic [13:0] VEC [6] = '{
        {10'd3, 4'd0}, {10'd2, 4'd1}, {10'd1, 4'd3},
        {10'd4, 4'd2}, {10'd1, 4'd0}, {10'd5, 4'd1}
    };

    function automatic logic [31:0] mkw(input logic en, input logic [7:0] deto,
                                        input logic [4:0] mdat, input logic [9:0] base);
        return {7'd0, base, mdat, deto, 1'b0, en};
    endfunction

    function automatic logic [31:0] rbk(input logic en, input logic [7:0] deto,
                                        input logic [4:0] mdat, input logic [9:0] base);
        return {3'd0, idle_mult, base, mdat, deto, dev_present, en & dev_present};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_pending = 1'b0; cmd_issue = 1'b0; ms_tick = 1'b0; reg_we = 1'b0;
        engine_run = 1'b0; slumber_only = 1'b0; ifc_state = 2'd0; lpm_block = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic pulse_issue();
        @(negedge clk) cmd_issue = 1'b1;
        @(negedge clk) cmd_issue = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < WDOG_CYCLES; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R11 / R1 reset state
        idle_mult = 4'd5;
        do_reset();
        chk("R11 devslp after reset", 32'(devslp), 32'd0);
        chk("R11 exit_busy after reset", 32'(exit_busy), 32'd0);
        chk("R1 reset readback", reg_rdata, rbk(1'b0, 8'd0, 5'd0, 10'd0));

        // R1 all-ones write, reserved bits read zero
        wr(32'hFFFF_FFFF);
        chk("R1 all-ones readback", reg_rdata, rbk(1'b1, 8'hFF, 5'h1F, 10'h3FF));
        dev_present = 1'b0;
        @(negedge clk);
        chk("R1 enable masked by present", reg_rdata, rbk(1'b1, 8'hFF, 5'h1F, 10'h3FF));
        chk("R1 enable bit zero without present", 32'(reg_rdata[0]), 32'd0);
        dev_present = 1'b1;

        // R2 timing fields locked while engine runs
        do_reset();
        wr(mkw(1'b0, 8'd4, 5'd3, 10'd5));
        engine_run = 1'b1;
        wr(mkw(1'b1, 8'd9, 5'd7, 10'd8));
        chk("R2 fields kept while running", reg_rdata, rbk(1'b1, 8'd4, 5'd3, 10'd5));
        engine_run = 1'b0;
        wr(mkw(1'b0, 8'd9, 5'd7, 10'd8));
        chk("R2 fields taken while stopped", reg_rdata, rbk(1'b0, 8'd9, 5'd7, 10'd8));

        // R3 vector table: idle limit = base*(mult+1)
        for (int v = 0; v < 6; v++) begin
            automatic logic [9:0] b = VEC[v][13:4];
            automatic int lim;
            idle_mult = VEC[v][3:0];
            lim = int'(b) * (int'(VEC[v][3:0]) + 1);
            do_reset();
            wr(mkw(1'b1, 8'd4, 5'd2, b));
            tick_n(lim - 1);
            chk($sformatf("R3 vec%0d before limit", v), 32'(devslp), 32'd0);
            tick_n(1);
            chk($sformatf("R3 vec%0d at limit", v), 32'(devslp), 32'd1);
        end
        idle_mult = 4'd0;

        // R6 / R7 explicit guard times
        do_reset();
        wr(mkw(1'b1, 8'd4, 5'd3, 10'd2));
        tick_n(2);
        chk("R3 asleep", 32'(devslp), 32'd1);
        pulse_issue();
        tick_n(2);
        chk("R6 held before min time", 32'(devslp), 32'd1);
        tick_n(1);
        chk("R6 released at min time", 32'(devslp), 32'd0);
        chk("R7 busy after release", 32'(exit_busy), 32'd1);
        tick_n(3);
        chk("R7 busy before exit timeout", 32'(exit_busy), 32'd1);
        tick_n(1);
        chk("R7 busy clears at exit timeout", 32'(exit_busy), 32'd0);
        tick_n(1);
        chk("R7 idle restarts from zero", 32'(devslp), 32'd0);
        tick_n(1);
        chk("R7 re-entry after fresh idle", 32'(devslp), 32'd1);

        // R6 / R7 default guard times
        do_reset();
        wr(mkw(1'b1, 8'd0, 5'd0, 10'd1));
        tick_n(1);
        pulse_issue();
        tick_n(9);
        chk("R6 default min time not yet", 32'(devslp), 32'd1);
        tick_n(1);
        chk("R6 default min time reached", 32'(devslp), 32'd0);
        tick_n(19);
        chk("R7 default exit not yet", 32'(exit_busy), 32'd1);
        tick_n(1);
        chk("R7 default exit reached", 32'(exit_busy), 32'd0);

        // R8 disable during sleep
        do_reset();
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd1));
        tick_n(1);
        wr(mkw(1'b0, 8'd4, 5'd2, 10'd1));
        tick_n(1);
        chk("R8 held until min time", 32'(devslp), 32'd1);
        tick_n(1);
        chk("R8 released", 32'(devslp), 32'd0);
        chk("R8 no busy on disable", 32'(exit_busy), 32'd0);
        tick_n(3);
        chk("R8 no re-entry while disabled", 32'(devslp), 32'd0);

        // R4 / R5 outstanding commands hold idle
        do_reset();
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd2));
        cmd_pending = 1'b1;
        tick_n(5);
        chk("R4 no sleep with pending", 32'(devslp), 32'd0);
        @(negedge clk) cmd_pending = 1'b0;
        tick_n(1);
        chk("R5 count restarted after pending", 32'(devslp), 32'd0);
        tick_n(1);
        chk("R5 sleep after full idle", 32'(devslp), 32'd1);

        do_reset();
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd3));
        tick_n(2);
        pulse_issue();
        tick_n(2);
        chk("R5 issue restarts count", 32'(devslp), 32'd0);
        tick_n(1);
        chk("R5 sleep after restart", 32'(devslp), 32'd1);

        // R4 zero base and disabled enable
        do_reset();
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd0));
        tick_n(5);
        chk("R4 zero base never sleeps", 32'(devslp), 32'd0);
        do_reset();
        wr(mkw(1'b0, 8'd4, 5'd2, 10'd1));
        tick_n(3);
        chk("R4 enable clear never sleeps", 32'(devslp), 32'd0);

        // R9 slumber-only entry
        do_reset();
        slumber_only = 1'b1;
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd1));
        tick_n(3);
        chk("R9 no entry from active", 32'(devslp), 32'd0);
        @(negedge clk) ifc_state = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk("R9 entry from slumber", 32'(devslp), 32'd1);

        // R10 transition blocks
        do_reset();
        lpm_block = 3'b100;
        wr(mkw(1'b1, 8'd4, 5'd2, 10'd1));
        tick_n(3);
        chk("R10 sleep blocked", 32'(devslp), 32'd0);
        chk("R10 lp_allow with bit2 only", 32'(lp_allow), 32'd3);
        chk("R10 link_hold with bit2 only", 32'(link_hold), 32'd0);
        @(negedge clk) lpm_block = 3'b111;
        @(negedge clk);
        chk("R10 lp_allow all blocked", 32'(lp_allow), 32'd0);
        chk("R10 link_hold all blocked", 32'(link_hold), 32'd1);
        chk("R10 still no sleep", 32'(devslp), 32'd0);
        @(negedge clk) lpm_block = 3'b001;
        @(negedge clk);
        @(negedge clk);
        chk("R10 lp_allow partial blocked", 32'(lp_allow), 32'd2);
        chk("R10 sleep once unblocked", 32'(devslp), 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule